// File: doc/BRIEF.md
# Sized Load/Store Byte-Lane Unit

This block is the memory-access stage of a small little-endian processor whose data memory is organised as 32-bit words. It takes a decoded memory instruction and turns it into a word-level memory request: a word address, a write strobe, per-lane byte enables and write data steered onto the correct byte lanes. When read data returns one cycle later, it picks out the addressed byte, 16-bit half or full word and zero-extends it to 32 bits.

The effective address comes in one of two forms. In the register-indirect form it is the value of a base register. In the stack-relative form it is the stack pointer plus a 6-bit unsigned displacement taken from the instruction. The register file and the data memory sit outside the block. The block receives the instruction's opcode nibble and its low operand byte, together with the register values the instruction names. Requests with the reserved size code, requests whose address is not aligned to the access size, and register-indirect requests with non-zero padding bits all count as faults. A faulting request never reaches memory and is reported one cycle later.

Top module: `lsu_lane_unit`

## Requirements
- R1: Opcode 4'b1000 is a register-indirect load, 4'b1001 a register-indirect store, 4'b1010 a stack-relative load and 4'b1011 a stack-relative store. Any other opcode makes no memory access (`mem_en_o` low), gives no load result and raises no fault. `mem_we_o` is high only for a store access.
- R2: In the register-indirect forms the byte address is `base_reg_i`. `mem_addr_o` carries byte-address bits [31:2] in the request cycle.
- R3: In the stack-relative forms the byte address is `stack_ptr_i` plus `operand_i[7:2]`, zero-extended.
- R4: A byte store (size code `operand_i[1:0]` = 0) drives `mem_be_o` = 1 << addr[1:0] and copies `store_src_i[7:0]` onto every lane of `mem_wdata_o`.
- R5: A 16-bit store (size code 1) drives `mem_be_o` = 4'b0011 when addr[1] is 0 and 4'b1100 when addr[1] is 1. It copies `store_src_i[15:0]` onto both halves of `mem_wdata_o`.
- R6: A 32-bit store (size code 2) drives `mem_be_o` = 4'b1111 and `mem_wdata_o` = `store_src_i`. Loads drive `mem_be_o` = 0.
- R7: A byte load raises `load_valid_o` in the cycle after the request. In that cycle `load_data_o` holds byte lane addr[1:0] of `mem_rdata_i` in bits [7:0], with zeros above.
- R8: A 16-bit load returns the half selected by addr[1], zero-extended. Lane 0 holds the less significant byte.
- R9: A 32-bit load returns `mem_rdata_i` unchanged.
- R10: Size code 3, a 16-bit access with addr[0] set, a 32-bit access with addr[1:0] not zero, or a register-indirect access with `operand_i[3:2]` not zero is a fault. A fault makes no memory access, so a faulting store leaves memory unchanged. In the next cycle a fault raises `fault_o` and leaves `load_valid_o` low.
- R11: While `rst` is high, and in the first cycle after it falls, `load_valid_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 4 | Instruction bits [15:12] |
| operand_i | input | 8 | Instruction bits [7:0]: base-register index or displacement, padding, size code |
| base_reg_i | input | 32 | Value of the base register |
| stack_ptr_i | input | 32 | Value of the stack pointer |
| store_src_i | input | 32 | Value of the store source register |
| mem_en_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte-lane write enables |
| mem_wdata_o | output | 32 | Lane-steered write data |
| mem_rdata_i | input | 32 | Word read data, one cycle after the access |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Zero-extended load result |
| fault_o | output | 1 | Previous request was rejected |

## Verification
The bench first fills memory and then walks every size through every aligned lane in both addressing forms. After each sub-word store it reads the whole word back. A design that steers data onto the wrong lane, or enables too many lanes, corrupts neighbouring bytes, and the bench sees that only in the full-word read. Sub-word loads are compared in full 32 bits, so missing zero-extension or a swapped half shows up at once. Faults are aimed at the edges: 16-bit accesses at lane 1, 32-bit accesses at lane 2, the reserved size code and a non-zero padding field. Each faulting store is followed by a read-back, which shows any write that leaked past the fault check. Displacements near 63 test that the stack-relative offset is zero-extended and not sign-extended.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN   = 32;
    localparam int LANES  = XLEN / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int DISP_W = 6;
    localparam int OPC_W  = 4;
    localparam int OPD_W  = 8;

    // Opcode bit 3..2 = 2'b10 marks a memory op, bit 1 the stack form, bit 0 a store
    localparam logic [1:0] OPC_MEM_CLASS = 2'b10;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef struct packed {
        logic              is_mem;
        logic              is_store;
        logic              use_sp;
        size_e             size;
        logic [DISP_W-1:0] disp;
        logic              pad_bad;
    } dec_t;

    typedef struct packed {
        size_e             size;
        logic [LANE_W-1:0] lane;
    } ld_ctx_t;

    function automatic dec_t decode_op(logic [OPC_W-1:0] opc, logic [OPD_W-1:0] opd);
        dec_t d;
        d.is_mem   = (opc[3:2] == OPC_MEM_CLASS);
        d.use_sp   = opc[1];
        d.is_store = opc[0];
        d.size     = size_e'(opd[1:0]);
        d.disp     = opd[7:2];
        d.pad_bad  = |opd[3:2];
        return d;
    endfunction

    function automatic logic lane_misaligned(size_e sz, logic [LANE_W-1:0] lane);
        logic bad;
        case (sz)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = lane[0];
            SZ_WORD: bad = |lane;
            default: bad = 1'b1;
        endcase
        return bad;
    endfunction

    function automatic logic [LANES-1:0] lane_enables(size_e sz, logic [LANE_W-1:0] lane);
        logic [LANES-1:0] en;
        case (sz)
            SZ_BYTE: en = LANES'(1) << lane;
            SZ_HALF: en = LANES'(3) << lane;
            SZ_WORD: en = '1;
            default: en = '0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 req_valid_i,
    input  logic [OPC_W-1:0]     opcode_i,
    input  logic [OPD_W-1:0]     operand_i,
    input  logic [ADDR_W-1:0]    base_i,
    input  logic [ADDR_W-1:0]    sp_i,
    output dec_t                 dec_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 go_o,
    output logic                 bad_o
);

    dec_t              dec;
    logic [ADDR_W-1:0] ea;
    logic              form_bad;

    always_comb begin
        dec = decode_op(opcode_i, operand_i);
        if (dec.use_sp) begin
            ea = sp_i + ADDR_W'(dec.disp);
        end else begin
            ea = base_i;
        end
        form_bad = (dec.size == SZ_RSVD)
                 || lane_misaligned(dec.size, ea[LANE_W-1:0])
                 || (!dec.use_sp && dec.pad_bad);
    end

    assign dec_o  = dec;
    assign addr_o = ea;
    assign bad_o  = req_valid_i && dec.is_mem && form_bad;
    assign go_o   = req_valid_i && dec.is_mem && !form_bad;

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
(
    input  size_e              size_i,
    input  logic [LANE_W-1:0]  lane_i,
    input  logic [XLEN-1:0]    src_i,
    output logic [LANES-1:0]   be_o,
    output logic [XLEN-1:0]    wdata_o
);

    assign be_o = lane_enables(size_i, lane_i);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            case (size_i)
                SZ_BYTE: wdata_o[8*i +: 8] = src_i[7:0];
                SZ_HALF: wdata_o[8*i +: 8] = src_i[8*(i%2) +: 8];
                default: wdata_o[8*i +: 8] = src_i[8*i +: 8];
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
    import lsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take_load_i,
    input  logic             take_fault_i,
    input  ld_ctx_t          ctx_i,
    input  logic [XLEN-1:0]  rdata_i,
    output logic             valid_o,
    output logic             fault_o,
    output logic [XLEN-1:0]  data_o
);

    ld_ctx_t    ctx_q;
    logic       valid_q;
    logic       fault_q;
    logic [7:0] lane_byte [LANES];
    logic [15:0] half_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q   <= '0;
            valid_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            valid_q <= take_load_i;
            fault_q <= take_fault_i;
            if (take_load_i) begin
                ctx_q <= ctx_i;
            end
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        assign lane_byte[i] = rdata_i[8*i +: 8];
    end

    assign half_sel = ctx_q.lane[LANE_W-1] ? rdata_i[31:16] : rdata_i[15:0];

    always_comb begin
        case (ctx_q.size)
            SZ_BYTE: data_o = XLEN'(lane_byte[ctx_q.lane]);
            SZ_HALF: data_o = XLEN'(half_sel);
            default: data_o = rdata_i;
        endcase
    end

    assign valid_o = valid_q;
    assign fault_o = fault_q;

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid_i,
    input  logic [3:0]                opcode_i,
    input  logic [7:0]                operand_i,
    input  logic [ADDR_W-1:0]         base_reg_i,
    input  logic [ADDR_W-1:0]         stack_ptr_i,
    input  logic [31:0]               store_src_i,
    output logic                      mem_en_o,
    output logic                      mem_we_o,
    output logic [ADDR_W-3:0]         mem_addr_o,
    output logic [3:0]                mem_be_o,
    output logic [31:0]               mem_wdata_o,
    input  logic [31:0]               mem_rdata_i,
    output logic                      load_valid_o,
    output logic [31:0]               load_data_o,
    output logic                      fault_o
);

    dec_t              dec;
    logic [ADDR_W-1:0] addr;
    logic              go;
    logic              bad;
    logic [LANES-1:0]  be_raw;
    ld_ctx_t           ctx;

    lsu_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid_i (req_valid_i),
        .opcode_i    (opcode_i),
        .operand_i   (operand_i),
        .base_i      (base_reg_i),
        .sp_i        (stack_ptr_i),
        .dec_o       (dec),
        .addr_o      (addr),
        .go_o        (go),
        .bad_o       (bad)
    );

    lsu_store_lanes u_store (
        .size_i  (dec.size),
        .lane_i  (addr[LANE_W-1:0]),
        .src_i   (store_src_i),
        .be_o    (be_raw),
        .wdata_o (mem_wdata_o)
    );

    assign ctx.size = dec.size;
    assign ctx.lane = addr[LANE_W-1:0];

    lsu_load_align u_load (
        .clk          (clk),
        .rst          (rst),
        .take_load_i  (go && !dec.is_store),
        .take_fault_i (bad),
        .ctx_i        (ctx),
        .rdata_i      (mem_rdata_i),
        .valid_o      (load_valid_o),
        .fault_o      (fault_o),
        .data_o       (load_data_o)
    );

    assign mem_en_o   = go;
    assign mem_we_o   = go && dec.is_store;
    assign mem_addr_o = addr[ADDR_W-1:LANE_W];
    assign mem_be_o   = (go && dec.is_store) ? be_raw : '0;

endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid_i,
    input logic [3:0]  opcode_i,
    input logic [1:0]  size_i,
    input logic        mem_en_o,
    input logic        mem_we_o,
    input logic [3:0]  mem_be_o,
    input logic        load_valid_o,
    input logic [31:0] load_data_o,
    input logic        fault_o
);

    assert_write_has_access_R1: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> mem_en_o);

    assert_access_is_memop_R1: assert property (@(posedge clk) disable iff (rst)
        mem_en_o |-> (req_valid_i && opcode_i[3:2] == 2'b10));

    assert_store_lane_shape_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> ($countones(mem_be_o) == 1 || mem_be_o == 4'b0011
                      || mem_be_o == 4'b1100 || mem_be_o == 4'b1111));

    assert_load_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_en_o && !mem_we_o) |-> (mem_be_o == 4'b0000));

    assert_load_after_read_R7: assert property (@(posedge clk) disable iff (rst)
        load_valid_o |-> $past(mem_en_o && !mem_we_o));

    assert_byte_zero_ext_R7: assert property (@(posedge clk) disable iff (rst)
        (load_valid_o && $past(size_i) == 2'd0) |-> (load_data_o[31:8] == 24'd0));

    assert_half_zero_ext_R8: assert property (@(posedge clk) disable iff (rst)
        (load_valid_o && $past(size_i) == 2'd1) |-> (load_data_o[31:16] == 16'd0));

    assert_fault_blocks_access_R10: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> ($past(req_valid_i) && !$past(mem_en_o)));

    assert_fault_excludes_load_R10: assert property (@(posedge clk) disable iff (rst)
        !(fault_o && load_valid_o));

    assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!load_valid_o && !fault_o));

endmodule

bind lsu_lane_unit lsu_lane_unit_chk u_chk (.*, .size_i(operand_i[1:0]));

// File: tb/test_lsu_lane_unit.sv
`timescale 1ns/1ps
module test_lsu_lane_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic [3:0]  opcode_i = '0;
    logic [7:0]  operand_i = '0;
    logic [31:0] base_reg_i = '0;
    logic [31:0] stack_ptr_i = '0;
    logic [31:0] store_src_i = '0;
    logic        mem_en_o, mem_we_o;
    logic [29:0] mem_addr_o;
    logic [3:0]  mem_be_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i;
    logic        load_valid_o;
    logic [31:0] load_data_o;
    logic        fault_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0]  ref_bytes [256];
    logic [31:0] mem [64];

    always #2 clk = ~clk;

    lsu_lane_unit i_lsu_lane_unit (.*);

    // Byte-enabled word memory with one cycle of read latency
    always @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < 64; w++) mem[w] <= '0;
            mem_rdata_i <= '0;
        end else if (mem_en_o) begin
            if (mem_we_o) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be_o[b]) mem[mem_addr_o[5:0]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
            end
            mem_rdata_i <= mem[mem_addr_o[5:0]];
        end
    end

    task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic logic [31:0] exp_load(logic [7:0] a, logic [1:0] sz);
        case (sz)
            2'd0:    return {24'd0, ref_bytes[a]};
            2'd1:    return {16'd0, ref_bytes[8'(a + 1)], ref_bytes[a]};
            default: return {ref_bytes[8'(a + 3)], ref_bytes[8'(a + 2)],
                             ref_bytes[8'(a + 1)], ref_bytes[a]};
        endcase
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] lane, logic [1:0] sz);
        case (sz)
            2'd0:    return 4'b0001 << lane;
            2'd1:    return lane[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_wdata(logic [31:0] s, logic [1:0] sz);
        case (sz)
            2'd0:    return {4{s[7:0]}};
            2'd1:    return {2{s[15:0]}};
            default: return s;
        endcase
    endfunction

    task automatic run_op(input logic [3:0] opc, input logic [7:0] opd,
                          input logic [31:0] base, input logic [31:0] sp, input logic [31:0] src);
        logic        is_mem, is_st, use_sp, flt;
        logic [1:0]  sz, lane;
        logic [31:0] a, ev;
        is_mem = (opc[3:2] == 2'b10);
        use_sp = opc[1];
        is_st  = opc[0];
        sz     = opd[1:0];
        a      = use_sp ? sp + {26'd0, opd[7:2]} : base;
        lane   = a[1:0];
        flt    = is_mem && (sz == 2'd3 || (sz == 2'd1 && lane[0]) || (sz == 2'd2 && lane != 2'd0)
                            || (!use_sp && opd[3:2] != 2'd0));
        @(negedge clk);
        req_valid_i = 1'b1; opcode_i = opc; operand_i = opd;
        base_reg_i = base; stack_ptr_i = sp; store_src_i = src;
        #1;
        check("R1/R10 access enable", mem_en_o == (is_mem && !flt), 32'(mem_en_o), 32'(is_mem && !flt));
        if (is_mem && !flt) begin
            check(use_sp ? "R3 stack address" : "R2 register address",
                  mem_addr_o == a[31:2], 32'(mem_addr_o), 32'(a[31:2]));
            check("R1 write strobe", mem_we_o == is_st, 32'(mem_we_o), 32'(is_st));
            if (is_st) begin
                ev = 32'(exp_be(lane, sz));
                check(sz == 0 ? "R4 byte enables" : sz == 1 ? "R5 half enables" : "R6 word enables",
                      mem_be_o == ev[3:0], 32'(mem_be_o), ev);
                ev = exp_wdata(src, sz);
                check(sz == 0 ? "R4 byte wdata" : sz == 1 ? "R5 half wdata" : "R6 word wdata",
                      mem_wdata_o == ev, mem_wdata_o, ev);
            end else begin
                check("R6 load strobe zero", mem_be_o == 4'b0000, 32'(mem_be_o), 32'd0);
            end
        end
        @(posedge clk);
        if (is_mem && !flt && is_st) begin
            ref_bytes[a[7:0]] = src[7:0];
            if (sz != 2'd0) ref_bytes[8'(a[7:0] + 1)] = src[15:8];
            if (sz == 2'd2) begin
                ref_bytes[8'(a[7:0] + 2)] = src[23:16];
                ref_bytes[8'(a[7:0] + 3)] = src[31:24];
            end
        end
        @(negedge clk);
        req_valid_i = 1'b0;
        #1;
        check("R10 fault flag", fault_o == flt, 32'(fault_o), 32'(flt));
        check("R7/R10 load valid", load_valid_o == (is_mem && !is_st && !flt),
              32'(load_valid_o), 32'(is_mem && !is_st && !flt));
        if (is_mem && !is_st && !flt) begin
            ev = exp_load(a[7:0], sz);
            check(sz == 0 ? "R7 byte load" : sz == 1 ? "R8 half load" : "R9 word load",
                  load_data_o == ev, load_data_o, ev);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] up, sp, src;
        logic [7:0]  opd;
        logic [1:0]  sz;
        void'($urandom(32'd20251));
        for (int i = 0; i < 256; i++) ref_bytes[i] = 8'd0;

        repeat (3) @(posedge clk);
        #1;
        check("R11 reset load_valid", load_valid_o == 1'b0, 32'(load_valid_o), 32'd0);
        check("R11 reset fault", fault_o == 1'b0, 32'(fault_o), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R11 first cycle quiet", !load_valid_o && !fault_o, 32'(load_valid_o | fault_o), 32'd0);

        // Fill memory with word stores, register-indirect form
        for (int w = 0; w < 64; w++)
            run_op(4'b1001, 8'h02, {$urandom() % 32'h100_0000, w[5:0], 2'b00}, 32'd0, $urandom());

        // Every size at every aligned lane in both forms
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 3; s++) begin
                for (int l = 0; l < 4; l += (1 << s)) begin
                    up  = $urandom();
                    src = $urandom();
                    if (f == 0) begin
                        opd = {4'($urandom()), 2'b00, 2'(s)};
                        run_op(4'b1001, opd, {up[31:8], up[7:2], 2'(l)}, 32'd0, src);
                        run_op(4'b1000, opd, {up[31:8], up[7:2], 2'(l)}, 32'd0, 32'd0);
                        run_op(4'b1000, {opd[7:4], 4'b0010}, {up[31:8], up[7:2], 2'b00}, 32'd0, 32'd0);
                    end else begin
                        sp  = {up[31:2], 2'b00};
                        opd = {4'($urandom()), 2'(l), 2'(s)};
                        run_op(4'b1011, opd, 32'd0, sp, src);
                        run_op(4'b1010, opd, 32'd0, sp, 32'd0);
                        run_op(4'b1010, {opd[7:4], 2'b00, 2'b10}, 32'd0, sp, 32'd0);
                    end
                end
            end
        end

        // Directed faults, each store followed by a word read-back
        run_op(4'b1001, 8'h03, 32'h40, 32'd0, 32'hDEADBEEF);  // R10 reserved size
        run_op(4'b1000, 8'h02, 32'h40, 32'd0, 32'd0);
        run_op(4'b1001, 8'h01, 32'h45, 32'd0, 32'h1234_5678); // R10 half at lane 1
        run_op(4'b1000, 8'h02, 32'h44, 32'd0, 32'd0);
        run_op(4'b1001, 8'h02, 32'h4A, 32'd0, 32'hCAFE_F00D); // R10 word at lane 2
        run_op(4'b1000, 8'h02, 32'h48, 32'd0, 32'd0);
        run_op(4'b1001, 8'h06, 32'h50, 32'd0, 32'h0BAD_0BAD); // R10 padding bits set
        run_op(4'b1000, 8'h02, 32'h50, 32'd0, 32'd0);
        run_op(4'b1011, {6'd1, 2'b10}, 32'd0, 32'h60, 32'h1111_2222); // R10 stack misaligned
        run_op(4'b1010, {6'd0, 2'b10}, 32'd0, 32'h60, 32'd0);
        run_op(4'b0000, 8'h02, 32'h40, 32'd0, 32'd0);         // R1 non-memory opcode
        run_op(4'b0110, 8'h02, 32'h40, 32'd0, 32'd0);         // R1 non-memory opcode
        run_op(4'b1010, {6'd63, 2'b00}, 32'd0, 32'h0000_0080, 32'd0); // R3 zero-extended offset
        run_op(4'b1011, {6'd60, 2'b10}, 32'd0, 32'hFFFF_FF80, 32'h5A5A_A5A5);
        run_op(4'b1010, {6'd60, 2'b10}, 32'd0, 32'hFFFF_FF80, 32'd0);

        // Constrained random mix
        for (int k = 0; k < 500; k++) begin
            logic [3:0] opc;
            logic [1:0] lane;
            opc = {2'b10, 1'($urandom()), 1'($urandom())};
            if ($urandom() % 16 == 0) opc = 4'($urandom());
            sz = ($urandom() % 8 == 0) ? 2'd3 : 2'($urandom() % 3);
            lane = (sz == 2'd0) ? 2'($urandom()) : (sz == 2'd1) ? {1'($urandom()), 1'b0} : 2'b00;
            if ($urandom() % 8 == 0) lane = 2'($urandom());
            up  = $urandom();
            src = $urandom();
            if (opc[1]) begin
                opd = {4'($urandom()), lane, sz};
                run_op(opc, opd, 32'd0, {up[31:2], 2'b00}, src);
            end else begin
                opd = {4'($urandom()), (($urandom() % 16 == 0) ? 2'($urandom()) : 2'b00), sz};
                run_op(opc, opd, {up[31:2], lane}, 32'd0, src);
            end
        end

        finish_up();
    end

endmodule